// File: doc/BRIEF.md
# Exception entry sequencer

This block carries out the fixed series of state updates a small 32-bit core makes when it enters an exception. Four causes compete: a bus fault and a break request, both raised by the core itself, a non-maskable interrupt, and a maskable interrupt whose vector comes from an external interrupt controller. The block decides in the idle state which cause, if any, may be taken. It then computes in one step every special register the entry changes: the saved return PC, the exception status word, the user and kernel stack pointers and the shifted status register. These results appear on the outputs with one-cycle write strobes for the core to capture.

After that step the block reads the handler address from a vector table in memory. The read goes through a single-word request/acknowledge port. When the word returns, the block raises a one-cycle done pulse with the new PC. No new request is looked at from acceptance until done.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `mem_req`, `ctx_we`, `erp_we`, `nrp_we`, `stk_we` and `dslot_clr` are all 0.
- R2: A maskable interrupt is taken only when the interrupt-enable flag (status bit 4) is 1 and `irq_lock` is 0. It uses `irq_vec` and saves the PC through the exception return output (`erp_we`).
- R3: A non-maskable interrupt is taken only when the M flag is 1. It uses vector 0, clears the M flag before the status shift, and saves the unadjusted PC through `nrp_we`/`nrp_out`. `erp_we` stays 0 for this cause.
- R4: The M flag is status bit 9 when `core_ver` is below 32, and status bit 30 when it is 32 or above.
- R5: A break request uses `trap_vec` and a bus fault uses `fault_vec`. Both save the PC through `erp_we`/`erp_out`.
- R6: When several causes are acceptable at once, the order from highest to lowest is bus fault, break, NMI, maskable interrupt.
- R7: `exs_out` holds bits 7:0 of the vector number in bits 15:8, with all other bits 0.
- R8: `erp_out` equals the PC minus `dslot_in`. `dslot_clr` pulses exactly when `dslot_in` is nonzero at acceptance.
- R9: When the user flag (status bit 8) is 1, `stk_we` pulses with `usp_out` equal to the old stack pointer and `sp_out` equal to `ksp_in`. When the flag is 0, `stk_we` stays 0.
- R10: `ccs_out` keeps bits 31:30 of the (M-adjusted) status word, carries its bits 19:0 in bits 29:10, and holds 0 in bits 9:0.
- R11: `mem_req` is raised with `mem_addr` equal to `ebp_in` plus four times the vector, and is held until `mem_ack`. The cycle after the acknowledge, `done` is 1 for one cycle with `new_pc` equal to `mem_data`, and the block is idle.
- R12: The block ignores every request from acceptance until `done`. No second set of strobes is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Maskable interrupt pending |
| irq_vec | input | 8 | Vector from interrupt controller |
| irq_lock | input | 1 | Blocks maskable interrupts |
| nmi_req | input | 1 | Non-maskable interrupt pending |
| brk_req | input | 1 | Break request from core |
| trap_vec | input | 8 | Vector for break |
| bf_req | input | 1 | Bus fault request from core |
| fault_vec | input | 8 | Vector for bus fault |
| core_ver | input | 8 | Core version value |
| pc_in | input | 32 | Current PC |
| ccs_in | input | 32 | Current status register |
| sp_in | input | 32 | Current stack pointer |
| ksp_in | input | 32 | Kernel stack pointer |
| ebp_in | input | 32 | Vector table base |
| dslot_in | input | 2 | Pending delay-slot count |
| busy | output | 1 | Entry in progress |
| ctx_we | output | 1 | Strobe for ccs_out and exs_out |
| ccs_out | output | 32 | New status register |
| exs_out | output | 32 | New exception status word |
| erp_we | output | 1 | Strobe for erp_out |
| erp_out | output | 32 | Exception return PC |
| nrp_we | output | 1 | Strobe for nrp_out |
| nrp_out | output | 32 | NMI return PC |
| stk_we | output | 1 | Strobe for usp_out and sp_out |
| usp_out | output | 32 | Saved user stack pointer |
| sp_out | output | 32 | New stack pointer |
| dslot_clr | output | 1 | Clear delay-slot count |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | 32 | Vector read address |
| mem_ack | input | 1 | Vector read acknowledge |
| mem_data | input | 32 | Vector read data |
| done | output | 1 | Entry complete pulse |
| new_pc | output | 32 | Handler address |

## Verification
All context strobes, their values, `busy`, `mem_req` and `mem_addr` come from registers loaded on the edge where the request is seen, so they are due exactly one cycle after the request is driven. The bench drives on the falling edge and checks at the next falling edge. `done` and `new_pc` are registered from the acknowledge edge, so they are checked one cycle after `mem_ack` is driven. During the wait the bench checks that `done` and the strobes stay low, and one cycle later it checks that `done` has dropped. The sweep covers every request combination, each flag setting, both sides of the version boundary, all delay-slot counts and acknowledge delays of 0 to 2 cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    CZ_NONE = 3'd0,
    CZ_IRQ  = 3'd1,
    CZ_NMI  = 3'd2,
    CZ_BRK  = 3'd3,
    CZ_BUS  = 3'd4
  } cause_e;

  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_FETCH = 1'b1
  } seq_state_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int VER_W     = 8,
  parameter int VER_SPLIT = 32
) (
  input  logic             irq_req,
  input  logic             irq_lock,
  input  logic             nmi_req,
  input  logic             brk_req,
  input  logic             bf_req,
  input  logic             ie_flag,
  input  logic             m_old_flag,
  input  logic             m_new_flag,
  input  logic [VER_W-1:0] core_ver,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] fault_vec,
  output logic             m_new,
  output cause_e           cause,
  output logic [VEC_W-1:0] vec
);
  localparam logic [VER_W-1:0] SPLIT = VER_W'(VER_SPLIT);

  logic m_flag;

  always_comb begin
    m_new  = (core_ver >= SPLIT);
    m_flag = m_new ? m_new_flag : m_old_flag;
    cause  = CZ_NONE;
    vec    = '0;
    if (bf_req) begin
      cause = CZ_BUS;
      vec   = fault_vec;
    end else if (brk_req) begin
      cause = CZ_BRK;
      vec   = trap_vec;
    end else if (nmi_req && m_flag) begin
      cause = CZ_NMI;
      vec   = '0;
    end else if (irq_req && ie_flag && !irq_lock) begin
      cause = CZ_IRQ;
      vec   = irq_vec;
    end
  end
endmodule

// File: rtl/exc_ctx_calc.sv
module exc_ctx_calc
  import exc_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int DSLOT_W   = 2,
  parameter int U_BIT     = 8,
  parameter int M_OLD_BIT = 9,
  parameter int M_NEW_BIT = 30
) (
  input  cause_e             cause,
  input  logic [VEC_W-1:0]   vec,
  input  logic               m_new,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    ccs,
  input  logic [XLEN-1:0]    sp,
  input  logic [XLEN-1:0]    ksp,
  input  logic [XLEN-1:0]    ebp,
  input  logic [DSLOT_W-1:0] dslot,
  output logic [XLEN-1:0]    erp_val,
  output logic [XLEN-1:0]    nrp_val,
  output logic [XLEN-1:0]    exs_val,
  output logic [XLEN-1:0]    ccs_val,
  output logic [XLEN-1:0]    usp_val,
  output logic [XLEN-1:0]    sp_val,
  output logic               swap,
  output logic [XLEN-1:0]    vec_addr
);
  localparam logic [XLEN-1:0] KEEP_HI  = 32'hC000_0000;
  localparam logic [XLEN-1:0] MOVE_MSK = 32'h3FFF_FC00;
  localparam logic [XLEN-1:0] M_OLD_MSK = XLEN'(1) << M_OLD_BIT;
  localparam logic [XLEN-1:0] M_NEW_MSK = XLEN'(1) << M_NEW_BIT;

  logic [XLEN-1:0] vec_ext;
  logic [XLEN-1:0] ds_ext;
  logic [XLEN-1:0] m_msk;
  logic [XLEN-1:0] ccs_m;

  always_comb begin
    vec_ext  = {{(XLEN-VEC_W){1'b0}}, vec};
    ds_ext   = {{(XLEN-DSLOT_W){1'b0}}, dslot};
    m_msk    = m_new ? M_NEW_MSK : M_OLD_MSK;
    ccs_m    = (cause == CZ_NMI) ? (ccs & ~m_msk) : ccs;
    ccs_val  = (ccs_m & KEEP_HI) | ((ccs_m << 10) & MOVE_MSK);
    exs_val  = {16'h0000, vec_ext[7:0], 8'h00};
    erp_val  = pc - ds_ext;
    nrp_val  = pc;
    swap     = ccs[U_BIT];
    usp_val  = sp;
    sp_val   = swap ? ksp : sp;
    vec_addr = ebp + (vec_ext << 2);
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int VER_W     = 8,
  parameter int VER_SPLIT = 32,
  parameter int DSLOT_W   = 2,
  parameter int IE_BIT    = 4,
  parameter int U_BIT     = 8,
  parameter int M_OLD_BIT = 9,
  parameter int M_NEW_BIT = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_req,
  input  logic [VEC_W-1:0]   irq_vec,
  input  logic               irq_lock,
  input  logic               nmi_req,
  input  logic               brk_req,
  input  logic [VEC_W-1:0]   trap_vec,
  input  logic               bf_req,
  input  logic [VEC_W-1:0]   fault_vec,
  input  logic [VER_W-1:0]   core_ver,
  input  logic [31:0]        pc_in,
  input  logic [31:0]        ccs_in,
  input  logic [31:0]        sp_in,
  input  logic [31:0]        ksp_in,
  input  logic [31:0]        ebp_in,
  input  logic [DSLOT_W-1:0] dslot_in,
  output logic               busy,
  output logic               ctx_we,
  output logic [31:0]        ccs_out,
  output logic [31:0]        exs_out,
  output logic               erp_we,
  output logic [31:0]        erp_out,
  output logic               nrp_we,
  output logic [31:0]        nrp_out,
  output logic               stk_we,
  output logic [31:0]        usp_out,
  output logic [31:0]        sp_out,
  output logic               dslot_clr,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  input  logic               mem_ack,
  input  logic [31:0]        mem_data,
  output logic               done,
  output logic [31:0]        new_pc
);
  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ok <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ok <= rst_s1;
    end
  end

  seq_state_e       state_q, state_d;
  cause_e           cause;
  logic [VEC_W-1:0] vec;
  logic             m_new;
  logic             take, fin;
  logic [31:0]      erp_val, nrp_val, exs_val, ccs_val, usp_val, sp_val, vec_addr;
  logic             swap;

  exc_arbiter #(
    .VEC_W(VEC_W), .VER_W(VER_W), .VER_SPLIT(VER_SPLIT)
  ) u_arb (
    .irq_req(irq_req), .irq_lock(irq_lock), .nmi_req(nmi_req),
    .brk_req(brk_req), .bf_req(bf_req),
    .ie_flag(ccs_in[IE_BIT]), .m_old_flag(ccs_in[M_OLD_BIT]),
    .m_new_flag(ccs_in[M_NEW_BIT]), .core_ver(core_ver),
    .irq_vec(irq_vec), .trap_vec(trap_vec), .fault_vec(fault_vec),
    .m_new(m_new), .cause(cause), .vec(vec)
  );

  exc_ctx_calc #(
    .VEC_W(VEC_W), .DSLOT_W(DSLOT_W), .U_BIT(U_BIT),
    .M_OLD_BIT(M_OLD_BIT), .M_NEW_BIT(M_NEW_BIT)
  ) u_calc (
    .cause(cause), .vec(vec), .m_new(m_new), .pc(pc_in), .ccs(ccs_in),
    .sp(sp_in), .ksp(ksp_in), .ebp(ebp_in), .dslot(dslot_in),
    .erp_val(erp_val), .nrp_val(nrp_val), .exs_val(exs_val),
    .ccs_val(ccs_val), .usp_val(usp_val), .sp_val(sp_val),
    .swap(swap), .vec_addr(vec_addr)
  );

  always_comb begin
    take    = (state_q == SQ_IDLE) && (cause != CZ_NONE);
    fin     = (state_q == SQ_FETCH) && mem_ack;
    state_d = state_q;
    case (state_q)
      SQ_IDLE:  if (take) state_d = SQ_FETCH;
      SQ_FETCH: if (mem_ack) state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  logic        ctx_we_q, erp_we_q, nrp_we_q, stk_we_q, dclr_q, done_q;
  logic [31:0] ccs_q, exs_q, erp_q, nrp_q, usp_q, sp_q, addr_q, npc_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      state_q  <= SQ_IDLE;
      ctx_we_q <= 1'b0;
      erp_we_q <= 1'b0;
      nrp_we_q <= 1'b0;
      stk_we_q <= 1'b0;
      dclr_q   <= 1'b0;
      done_q   <= 1'b0;
      ccs_q    <= '0;
      exs_q    <= '0;
      erp_q    <= '0;
      nrp_q    <= '0;
      usp_q    <= '0;
      sp_q     <= '0;
      addr_q   <= '0;
      npc_q    <= '0;
    end else begin
      state_q  <= state_d;
      ctx_we_q <= take;
      erp_we_q <= take && (cause != CZ_NMI);
      nrp_we_q <= take && (cause == CZ_NMI);
      stk_we_q <= take && swap;
      dclr_q   <= take && (dslot_in != '0);
      done_q   <= fin;
      if (take) begin
        ccs_q  <= ccs_val;
        exs_q  <= exs_val;
        erp_q  <= erp_val;
        nrp_q  <= nrp_val;
        usp_q  <= usp_val;
        sp_q   <= sp_val;
        addr_q <= vec_addr;
      end
      if (fin) npc_q <= mem_data;
    end
  end

  assign busy      = (state_q != SQ_IDLE);
  assign mem_req   = (state_q == SQ_FETCH);
  assign mem_addr  = addr_q;
  assign ctx_we    = ctx_we_q;
  assign ccs_out   = ccs_q;
  assign exs_out   = exs_q;
  assign erp_we    = erp_we_q;
  assign erp_out   = erp_q;
  assign nrp_we    = nrp_we_q;
  assign nrp_out   = nrp_q;
  assign stk_we    = stk_we_q;
  assign usp_out   = usp_q;
  assign sp_out    = sp_q;
  assign dslot_clr = dclr_q;
  assign done      = done_q;
  assign new_pc    = npc_q;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ctx_we,
  input logic [31:0] ccs_out,
  input logic [31:0] exs_out,
  input logic        erp_we,
  input logic        nrp_we,
  input logic        stk_we,
  input logic        dslot_clr,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic [31:0] mem_data,
  input logic        done,
  input logic [31:0] new_pc
);
  a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (done && !busy && new_pc == $past(mem_data)));

  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_no_retake: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_we |-> $past(!busy));

  a_r3_one_return: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erp_we, nrp_we}));

  a_r10_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_we |-> (ccs_out[9:0] == 10'd0));

  a_r7_exs_fields: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_we |-> (exs_out[31:16] == 16'd0 && exs_out[7:0] == 8'd0));

  a_r9_stack_with_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we || dslot_clr) |-> (ctx_we && busy));
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ctx_we(ctx_we),
  .ccs_out(ccs_out), .exs_out(exs_out), .erp_we(erp_we), .nrp_we(nrp_we),
  .stk_we(stk_we), .dslot_clr(dslot_clr), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
  .done(done), .new_pc(new_pc)
);

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 0, irq_lock = 0, nmi_req = 0, brk_req = 0, bf_req = 0;
  logic [7:0]  irq_vec = 0, trap_vec = 0, fault_vec = 0, core_ver = 0;
  logic [31:0] pc_in = 0, ccs_in = 0, sp_in = 0, ksp_in = 0, ebp_in = 0;
  logic [1:0]  dslot_in = 0;
  logic        mem_ack = 0;
  logic [31:0] mem_data = 0;
  logic        busy, ctx_we, erp_we, nrp_we, stk_we, dslot_clr, mem_req, done;
  logic [31:0] ccs_out, exs_out, erp_out, nrp_out, usp_out, sp_out, mem_addr, new_pc;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  exc_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_lock(irq_lock), .nmi_req(nmi_req), .brk_req(brk_req),
    .trap_vec(trap_vec), .bf_req(bf_req), .fault_vec(fault_vec),
    .core_ver(core_ver), .pc_in(pc_in), .ccs_in(ccs_in), .sp_in(sp_in),
    .ksp_in(ksp_in), .ebp_in(ebp_in), .dslot_in(dslot_in), .busy(busy),
    .ctx_we(ctx_we), .ccs_out(ccs_out), .exs_out(exs_out), .erp_we(erp_we),
    .erp_out(erp_out), .nrp_we(nrp_we), .nrp_out(nrp_out), .stk_we(stk_we),
    .usp_out(usp_out), .sp_out(sp_out), .dslot_clr(dslot_clr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_data(mem_data), .done(done), .new_pc(new_pc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input bit bf, input bit brk, input bit nmi, input bit irq,
                          input bit ie, input bit lock, input bit mset, input bit u,
                          input bit vnew, input int ds, input int idx);
    logic [31:0] ccs, ccs1, ccs_exp, addr, data, pc, sp, ksp, ebp;
    logic [7:0]  vec, ver;
    int cz;
    int waitn;
    ccs = 32'h6B2D_E4A1 ^ (idx * 32'h0001_3579);
    ccs[4] = ie; ccs[8] = u;
    if (vnew) begin ccs[30] = mset; ccs[9] = !mset; end
    else      begin ccs[9] = mset;  ccs[30] = !mset; end
    ver = vnew ? 8'(32 + ds * 7) : 8'(31 - ds * 8);
    pc  = 32'h0040_1000 + 32'(idx * 4);
    sp  = 32'h7FFF_E000 - 32'(idx * 16);
    ksp = 32'hC010_0000 + 32'(idx);
    ebp = 32'h8000_0F00 + 32'(ds * 32'h100);
    waitn = idx % 3;

    // expected cause by priority: bus fault, break, NMI, maskable (R6)
    if (bf) begin cz = 4; vec = 8'h23 + 8'(ds); end
    else if (brk) begin cz = 3; vec = 8'h11; end
    else if (nmi && mset) begin cz = 2; vec = 8'h00; end
    else if (irq && ie && !lock) begin cz = 1; vec = 8'h40 + 8'(ds); end
    else begin cz = 0; vec = 8'h00; end

    ccs1 = ccs;
    if (cz == 2) begin
      if (vnew) ccs1[30] = 1'b0; else ccs1[9] = 1'b0;
    end
    ccs_exp = {ccs1[31:30], ccs1[19:0], 10'b0};
    addr = ebp + {22'd0, vec, 2'b00};
    data = addr ^ 32'hC3C3_5A5A;

    @(negedge clk);
    bf_req = bf; brk_req = brk; nmi_req = nmi; irq_req = irq;
    irq_lock = lock; ccs_in = ccs; core_ver = ver; pc_in = pc; sp_in = sp;
    ksp_in = ksp; ebp_in = ebp; dslot_in = 2'(ds);
    fault_vec = 8'h23 + 8'(ds); trap_vec = 8'h11; irq_vec = 8'h40 + 8'(ds);
    @(negedge clk);
    bf_req = 0; brk_req = 0; nmi_req = 0; irq_req = 0;
    if (cz == 0) begin
      chk(!busy && !ctx_we, "R2 R3 no cause accepted", {31'd0, busy}, 32'd0);
      return;
    end
    chk(busy && ctx_we && mem_req, "R11 entry started", {29'd0, busy, ctx_we, mem_req}, 32'd7);
    chk(mem_addr == addr, "R11 vector address", mem_addr, addr);
    chk(ccs_out == ccs_exp, (cz == 2) ? "R3 R4 R10 status" : "R10 status shift", ccs_out, ccs_exp);
    chk(exs_out == {16'd0, vec, 8'd0}, "R7 exception status", exs_out, {16'd0, vec, 8'd0});
    if (cz == 2) begin
      chk(nrp_we && !erp_we && nrp_out == pc, "R3 NMI return", nrp_out, pc);
    end else begin
      chk(erp_we && !nrp_we && erp_out == pc - 32'(ds),
          (cz == 1) ? "R2 R8 return" : "R5 R8 return", erp_out, pc - 32'(ds));
    end
    chk(dslot_clr == (ds != 0), "R8 delay slot clear", {31'd0, dslot_clr}, {31'd0, ds != 0});
    chk(stk_we == u, "R9 stack strobe", {31'd0, stk_we}, {31'd0, u});
    if (u) chk(usp_out == sp && sp_out == ksp, "R9 stack swap", sp_out, ksp);
    chk(vec == 8'h23 + 8'(ds) || cz != 4, "R6 priority", {29'd0, 3'(cz)}, 32'd4);

    // new request while busy must be ignored (R12)
    bf_req = 1;
    for (int w = 0; w < waitn; w++) begin
      @(negedge clk);
      chk(mem_req && !done && !ctx_we && !erp_we && !nrp_we, "R12 ignored while fetching",
          {30'd0, mem_req, ctx_we}, 32'd2);
    end
    mem_ack = 1; mem_data = data;
    @(negedge clk);
    mem_ack = 0; bf_req = 0;
    chk(done && new_pc == data, "R11 done with new PC", new_pc, data);
    chk(!busy && !mem_req && !ctx_we, "R12 idle after done", {30'd0, busy, ctx_we}, 32'd0);
    @(negedge clk);
    chk(!done && !busy, "R11 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #1;
    chk(!busy && !done && !mem_req && !ctx_we && !erp_we && !nrp_we && !stk_we && !dslot_clr,
        "R1 reset state", {31'd0, busy}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 idle after reset", {31'd0, busy}, 32'd0);
    for (int q = 0; q < 16; q++)
      for (int f = 0; f < 32; f++)
        for (int ds = 0; ds < 4; ds++)
          run_case(q[3], q[2], q[1], q[0], f[0], f[1], f[2], f[3], f[4], ds,
                   q * 128 + f * 4 + ds);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule